// File: doc/BRIEF.md
# Cursor Generator Host Register Port

This block is the host-facing register side of a hardware cursor generator. A 16-bit host bus reaches four ports, picked by a 2-bit port select. Two of the ports load a 16-bit internal pointer one byte at a time. The other two are data windows. The register-data window moves one byte per access into or out of a small indirect register file. The cursor-map window moves one 16-bit word per access into or out of a 512-word cursor bitmap memory. Every data access advances the pointer, so the host can stream a run of registers, or the whole bitmap, after a single pointer load.

The register file holds the command byte, the cursor X and Y position, and the crosshair window origin, width and height. These values go straight to the video side as steady outputs. The video side also has its own read port into the bitmap memory. Host reads are registered: the data appears one cycle after the read strobe and is flagged by a valid pulse.

Top module: `cursor_reg_port`

## Requirements
- R1: Port select 0 writes the pointer's low byte and port select 1 writes its high byte, each taken from busWdata[7:0]. Reading either port returns that pointer byte in bits [7:0]. Writing the low byte alone leaves the high byte as it was.
- R2: Byte writes use only busWdata[7:0], and the upper lane is ignored. Byte reads from ports 0, 1 and 3 return the byte in busRdata[7:0], with busRdata[15:8] equal to zero.
- R3: Register indices map as follows. Index 0x00 is cmdOut. 0x01 and 0x02 are the low and high bytes of cursorX. 0x03 and 0x04 are the low and high bytes of cursorY. 0x05/0x06 form winX, 0x07/0x08 winY, 0x09/0x0A winW and 0x0B/0x0C winH, each as a low/high pair.
- R4: Each read or write through port 3 (register data) adds one to the 16-bit pointer, so consecutive accesses step through consecutive registers.
- R5: The high bytes of the cursor position (indices 0x02 and 0x04) keep only bits [3:0]. They read back with the upper nibble at zero, and cursorX and cursorY are 12 bits wide.
- R6: A port 3 access at an index above 0x0C writes nothing and reads back 0x00, and the pointer still increments.
- R7: A port 2 (cursor map) write stores the full 16-bit word at pointer bits [8:0]. A port 2 read returns that word unchanged. Both advance the pointer.
- R8: A port 2 access at map address 0x1FF leaves the pointer at 0x0000.
- R9: Read data appears on busRdata in the cycle after a read strobe, with rdValid high for exactly that cycle. With no read, rdValid stays low.
- R10: Reset clears the command, position and window registers and the pointer to zero.
- R11: vidData returns the bitmap word at vidAddr one cycle after vidAddr is presented.
- R12: When busWr and busRd are both high, the write is carried out and the read is dropped, so no rdValid follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 2 | Port select: 0 pointer low, 1 pointer high, 2 cursor map, 3 register data |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, valid with rdValid |
| rdValid | output | 1 | Read data valid, one cycle after the read |
| vidAddr | input | 9 | Video-side bitmap read address |
| vidData | output | 16 | Video-side bitmap word, one cycle after vidAddr |
| cmdOut | output | 8 | Command register |
| cursorX | output | 12 | Cursor X position |
| cursorY | output | 12 | Cursor Y position |
| winX | output | 16 | Crosshair window X |
| winY | output | 16 | Crosshair window Y |
| winW | output | 16 | Crosshair window width |
| winH | output | 16 | Crosshair window height |

## Verification
The bench builds the block with its default parameters: a 512-word map, 13 registers and 12-bit coordinates. At these values the map wrap at 0x1FF, the walk past the last register index into the empty space above it, and the 16-bit pointer rollover from 0xFFFF are all reachable with short access runs. The address-port readback shows where the pointer lands after each of these runs, so increment and wrap are checked at the pins.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  typedef enum logic [1:0] {
    PORT_PTR_LO = 2'd0,
    PORT_PTR_HI = 2'd1,
    PORT_MAP    = 2'd2,
    PORT_REG    = 2'd3
  } portSel_e;

  // Strobes from the decoder to the datapath, at most one high per cycle.
  typedef struct packed {
    logic ldLo;
    logic ldHi;
    logic regWr;
    logic regRd;
    logic mapWr;
    logic mapRd;
    logic rdLo;
    logic rdHi;
  } strobes_t;
endpackage

// File: rtl/cursor_ctrl.sv
module cursor_ctrl
  import cursor_pkg::*;
(
  input  logic [1:0] busSel,
  input  logic       busWr,
  input  logic       busRd,
  output strobes_t   stb
);
  logic rdEn;
  portSel_e sel;

  assign sel  = portSel_e'(busSel);
  assign rdEn = busRd & ~busWr;  // a write wins over a read in the same cycle

  always_comb begin
    stb       = '0;
    stb.ldLo  = busWr && (sel == PORT_PTR_LO);
    stb.ldHi  = busWr && (sel == PORT_PTR_HI);
    stb.mapWr = busWr && (sel == PORT_MAP);
    stb.regWr = busWr && (sel == PORT_REG);
    stb.rdLo  = rdEn  && (sel == PORT_PTR_LO);
    stb.rdHi  = rdEn  && (sel == PORT_PTR_HI);
    stb.mapRd = rdEn  && (sel == PORT_MAP);
    stb.regRd = rdEn  && (sel == PORT_REG);
  end
endmodule

// File: rtl/cursor_dp.sv
module cursor_dp
  import cursor_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int PTR_W     = 16,
  parameter int MAP_DEPTH = 512,
  parameter int REG_COUNT = 13,
  parameter int COORD_W   = 12
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobes_t                      stb,
  input  logic [DATA_W-1:0]             busWdata,
  output logic [DATA_W-1:0]             busRdata,
  output logic                          rdValid,
  input  logic [$clog2(MAP_DEPTH)-1:0]  vidAddr,
  output logic [DATA_W-1:0]             vidData,
  output logic [7:0]                    cmdOut,
  output logic [COORD_W-1:0]            cursorX,
  output logic [COORD_W-1:0]            cursorY,
  output logic [15:0]                   winX,
  output logic [15:0]                   winY,
  output logic [15:0]                   winW,
  output logic [15:0]                   winH
);
  localparam int BYTE_W  = 8;
  localparam int MAP_AW  = $clog2(MAP_DEPTH);
  localparam int IDX_W   = $clog2(REG_COUNT);
  localparam int HI_BITS = COORD_W - BYTE_W;
  localparam logic [BYTE_W-1:0] HI_MASK = BYTE_W'((1 << HI_BITS) - 1);
  localparam int IDX_CMD = 0, IDX_XLO = 1, IDX_XHI = 2, IDX_YLO = 3, IDX_YHI = 4;
  localparam int IDX_WIN = 5;

  logic [PTR_W-1:0]   ptrQ;
  logic [BYTE_W-1:0]  regFile [REG_COUNT];
  logic [DATA_W-1:0]  mapMem  [MAP_DEPTH];
  logic [DATA_W-1:0]  mapQ;
  logic [BYTE_W-1:0]  byteQ;
  logic               selMapQ;
  logic [MAP_AW-1:0]  mapAddr, mapNext;
  logic [IDX_W-1:0]   regIdx;
  logic               regHit;
  logic [BYTE_W-1:0]  regRdByte;

  assign mapAddr = ptrQ[MAP_AW-1:0];
  assign mapNext = mapAddr + 1'b1;  // wraps inside the map
  assign regIdx  = ptrQ[IDX_W-1:0];
  assign regHit  = ptrQ < PTR_W'(REG_COUNT);
  assign regRdByte = regHit ? regFile[regIdx] : '0;

  // Pointer: byte loads and post-increment after every data access.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ <= '0;
    end else if (stb.ldLo) begin
      ptrQ[BYTE_W-1:0] <= busWdata[BYTE_W-1:0];
    end else if (stb.ldHi) begin
      ptrQ[PTR_W-1:BYTE_W] <= busWdata[PTR_W-BYTE_W-1:0];
    end else if (stb.regWr || stb.regRd) begin
      ptrQ <= ptrQ + 1'b1;
    end else if (stb.mapWr || stb.mapRd) begin
      ptrQ <= {{(PTR_W-MAP_AW){1'b0}}, mapNext};
    end
  end

  // Indirect register file; position high bytes keep only the coordinate bits.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < REG_COUNT; i++) regFile[i] <= '0;
    end else if (stb.regWr && regHit) begin
      if (int'(regIdx) == IDX_XHI || int'(regIdx) == IDX_YHI)
        regFile[regIdx] <= busWdata[BYTE_W-1:0] & HI_MASK;
      else
        regFile[regIdx] <= busWdata[BYTE_W-1:0];
    end
  end

  // Bitmap memory, host port plus an independent video read port.
  always_ff @(posedge clk) begin
    if (stb.mapWr) mapMem[mapAddr] <= busWdata;
    mapQ    <= mapMem[mapAddr];
    vidData <= mapMem[vidAddr];
  end

  // Read return path.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      selMapQ <= 1'b0;
      byteQ   <= '0;
    end else begin
      rdValid <= stb.regRd | stb.mapRd | stb.rdLo | stb.rdHi;
      selMapQ <= stb.mapRd;
      if (stb.regRd)     byteQ <= regRdByte;
      else if (stb.rdLo) byteQ <= ptrQ[BYTE_W-1:0];
      else if (stb.rdHi) byteQ <= ptrQ[PTR_W-1:BYTE_W];
    end
  end

  assign busRdata = selMapQ ? mapQ : {{(DATA_W-BYTE_W){1'b0}}, byteQ};

  assign cmdOut  = regFile[IDX_CMD];
  assign cursorX = {regFile[IDX_XHI][HI_BITS-1:0], regFile[IDX_XLO]};
  assign cursorY = {regFile[IDX_YHI][HI_BITS-1:0], regFile[IDX_YLO]};
  assign winX    = {regFile[IDX_WIN+1], regFile[IDX_WIN+0]};
  assign winY    = {regFile[IDX_WIN+3], regFile[IDX_WIN+2]};
  assign winW    = {regFile[IDX_WIN+5], regFile[IDX_WIN+4]};
  assign winH    = {regFile[IDX_WIN+7], regFile[IDX_WIN+6]};
endmodule

// File: rtl/cursor_reg_port.sv
module cursor_reg_port
  import cursor_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int PTR_W     = 16,
  parameter int MAP_DEPTH = 512,
  parameter int REG_COUNT = 13,
  parameter int COORD_W   = 12
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [1:0]                   busSel,
  input  logic                         busWr,
  input  logic                         busRd,
  input  logic [DATA_W-1:0]            busWdata,
  output logic [DATA_W-1:0]            busRdata,
  output logic                         rdValid,
  input  logic [$clog2(MAP_DEPTH)-1:0] vidAddr,
  output logic [DATA_W-1:0]            vidData,
  output logic [7:0]                   cmdOut,
  output logic [COORD_W-1:0]           cursorX,
  output logic [COORD_W-1:0]           cursorY,
  output logic [15:0]                  winX,
  output logic [15:0]                  winY,
  output logic [15:0]                  winW,
  output logic [15:0]                  winH
);
  strobes_t stb;

  cursor_ctrl u_ctrl (
    .busSel (busSel),
    .busWr  (busWr),
    .busRd  (busRd),
    .stb    (stb)
  );

  cursor_dp #(
    .DATA_W    (DATA_W),
    .PTR_W     (PTR_W),
    .MAP_DEPTH (MAP_DEPTH),
    .REG_COUNT (REG_COUNT),
    .COORD_W   (COORD_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .rdValid  (rdValid),
    .vidAddr  (vidAddr),
    .vidData  (vidData),
    .cmdOut   (cmdOut),
    .cursorX  (cursorX),
    .cursorY  (cursorY),
    .winX     (winX),
    .winY     (winY),
    .winW     (winW),
    .winH     (winH)
  );
endmodule

// File: rtl/cursor_reg_port_chk.sv
module cursor_reg_port_chk #(
  parameter int DATA_W    = 16,
  parameter int COORD_W   = 12
) (
  input logic               clk,
  input logic               rstN,
  input logic [1:0]         busSel,
  input logic               busWr,
  input logic               busRd,
  input logic [DATA_W-1:0]  busWdata,
  input logic [DATA_W-1:0]  busRdata,
  input logic               rdValid,
  input logic [7:0]         cmdOut,
  input logic [COORD_W-1:0] cursorX,
  input logic [COORD_W-1:0] cursorY
);
  AST_RD_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && !busWr) |=> rdValid);  // R9

  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && !busWr) |=> !rdValid);  // R12

  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && !busWr && busSel != 2'd2) |=> busRdata[DATA_W-1:8] == '0);  // R2

  AST_PTR_LO_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busSel == 2'd0) ##1 (busRd && !busWr && busSel == 2'd0)
      |=> busRdata[7:0] == $past(busWdata[7:0], 2));  // R1

  AST_PTR_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busSel[1] == 1'b0) |=> $stable(cmdOut) && $stable(cursorX) && $stable(cursorY));  // R1

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !busWr |=> $stable(cmdOut) && $stable(cursorX) && $stable(cursorY));  // R3
endmodule

bind cursor_reg_port cursor_reg_port_chk #(.DATA_W(DATA_W), .COORD_W(COORD_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWr    (busWr),
  .busRd    (busRd),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .rdValid  (rdValid),
  .cmdOut   (cmdOut),
  .cursorX  (cursorX),
  .cursorY  (cursorY)
);

// File: tb/cursor_reg_port_test.sv
`timescale 1ns/1ps
module cursor_reg_port_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  busSel = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        rdValid;
  logic [8:0]  vidAddr = '0;
  logic [15:0] vidData;
  logic [7:0]  cmdOut;
  logic [11:0] cursorX, cursorY;
  logic [15:0] winX, winY, winW, winH;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [15:0] val;
    string       tag;
  } expItem_t;
  expItem_t expQ[$];

  always #5 clk = ~clk;

  cursor_reg_port uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .rdValid(rdValid),
    .vidAddr(vidAddr), .vidData(vidData), .cmdOut(cmdOut),
    .cursorX(cursorX), .cursorY(cursorY),
    .winX(winX), .winY(winY), .winW(winW), .winH(winH)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read data when the design flags it.
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        nChecks++;
        nFails++;
        $display("FAIL R9/R12: actual unexpected rdValid data 0x%0h expected no read", busRdata);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(e.tag, {16'h0, busRdata}, {16'h0, e.val});
      end
    end
  end

  task automatic drive(input logic [1:0] s, input logic w, input logic r, input logic [15:0] d);
    @(negedge clk);
    busSel = s; busWr = w; busRd = r; busWdata = d;
    @(negedge clk);
    busWr = 1'b0; busRd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    drive(s, 1'b1, 1'b0, d);
  endtask

  task automatic wrByte(input logic [7:0] b);
    wr(2'd3, {b, b});
  endtask

  task automatic rd(input logic [1:0] s, input logic [15:0] exp, input string tag);
    expItem_t e;
    e.val = exp; e.tag = tag;
    expQ.push_back(e);
    drive(s, 1'b0, 1'b1, 16'h0);
  endtask

  task automatic setPtr(input logic [15:0] p);
    wr(2'd0, {p[7:0], p[7:0]});
    wr(2'd1, {p[15:8], p[15:8]});
  endtask

  function automatic logic [15:0] pat(input int i);
    return 16'(i * 16'h1357) ^ 16'hA5C3;
  endfunction

  initial begin
    #(200000 * 10);
    nFails++;
    $display("FAIL watchdog: actual run still active expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R10 reset state
    check("R10 cmd", cmdOut, 0);
    check("R10 cursorX", cursorX, 0);
    check("R10 cursorY", cursorY, 0);
    check("R10 winH", winH, 0);
    rd(2'd0, 16'h0000, "R10 ptr lo");
    rd(2'd1, 16'h0000, "R10 ptr hi");

    // R3 R4 R5 position stream
    setPtr(16'h0001);
    wrByte(8'h34); wrByte(8'hA2); wrByte(8'h78); wrByte(8'hF5);
    check("R5 cursorX", cursorX, 12'h234);
    check("R5 cursorY", cursorY, 12'h578);
    rd(2'd0, 16'h0005, "R4 ptr after four writes");
    setPtr(16'h0001);
    rd(2'd3, 16'h0034, "R2 X lo read");
    rd(2'd3, 16'h0002, "R5 X hi nibble");
    rd(2'd3, 16'h0078, "R2 Y lo read");
    rd(2'd3, 16'h0005, "R5 Y hi nibble");

    // R2 lane handling on the command register
    setPtr(16'h0000);
    wr(2'd3, 16'hFF54);
    check("R2 upper lane ignored", cmdOut, 8'h54);

    // R3 window walk
    setPtr(16'h0005);
    for (int i = 1; i <= 8; i++) wrByte(8'(i * 8'h11));
    check("R3 winX", winX, 16'h2211);
    check("R3 winY", winY, 16'h4433);
    check("R3 winW", winW, 16'h6655);
    check("R3 winH", winH, 16'h8877);

    // R1 low byte alone
    setPtr(16'h0123);
    wr(2'd0, 16'h4545);
    rd(2'd0, 16'h0045, "R1 lo loaded");
    rd(2'd1, 16'h0001, "R1 hi kept");

    // R6 out-of-range index
    setPtr(16'h000D);
    wrByte(8'h99);
    rd(2'd0, 16'h000E, "R6 ptr steps on empty write");
    check("R6 cmd untouched", cmdOut, 8'h54);
    check("R6 winH untouched", winH, 16'h8877);
    setPtr(16'h000D);
    rd(2'd3, 16'h0000, "R6 empty reads zero");
    rd(2'd0, 16'h000E, "R6 ptr steps on empty read");
    setPtr(16'hFFFF);
    wrByte(8'h77);
    rd(2'd0, 16'h0000, "R4 pointer rollover lo");
    rd(2'd1, 16'h0000, "R4 pointer rollover hi");

    // R7 map word stream
    setPtr(16'h0000);
    for (int i = 0; i < 16; i++) wr(2'd2, pat(i));
    rd(2'd0, 16'h0010, "R7 ptr after map writes");
    setPtr(16'h0000);
    for (int i = 0; i < 16; i++) rd(2'd2, pat(i), "R7 map readback");

    // R8 wrap at the end of the map
    setPtr(16'h01FE);
    wr(2'd2, 16'hBEEF);
    wr(2'd2, 16'hC0DE);
    rd(2'd0, 16'h0000, "R8 wrap lo");
    rd(2'd1, 16'h0000, "R8 wrap hi");
    wr(2'd2, 16'h5A5A);
    setPtr(16'h01FE);
    rd(2'd2, 16'hBEEF, "R8 word 0x1FE");
    rd(2'd2, 16'hC0DE, "R8 word 0x1FF");
    rd(2'd2, 16'h5A5A, "R8 wrapped to 0");

    // R11 video port
    @(negedge clk); vidAddr = 9'h1FF;
    @(negedge clk); check("R11 video word", vidData, 16'hC0DE);
    vidAddr = 9'h003;
    @(negedge clk); check("R11 video word 3", vidData, pat(3));

    // R12 write and read together
    setPtr(16'h0000);
    drive(2'd3, 1'b1, 1'b1, 16'h6363);
    @(negedge clk);
    check("R12 write done", cmdOut, 8'h63);
    check("R12 no read queued", expQ.size(), 0);

    repeat (3) @(negedge clk);
    check("R9 all reads returned", expQ.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule